// File: doc/BRIEF.md
# Two-Channel Disk Controller Register File

This block is the memory-mapped register file of a disk controller with two channels. It is attached to a simple synchronous register bus. Each access carries an address, a size code, a read or write strobe and 32-bit write data, and read data comes back registered. For each channel the block stores the bus-master DMA command byte, the DMA status byte, a 6-bit scratch byte, a 12-bit SATA control field, a 16-bit interrupt-enable field and a device interrupt flag.

The block also builds two packed status words that merge the channels' DMA status with their interrupt flags. It drives one interrupt line, which is the OR of the two channel flags. Accesses to the task-file window and to the DMA address registers are not stored here. They are handed on through per-channel request strobes, and the value the channel returns is captured as read data.

A write to a SATA control field with bit 0 set sends a one-cycle reset pulse to that channel. The drive protocol engine, the DMA engine and PCI configuration space are outside this block. The DMA engine reports to the block through the active, error and interrupt inputs.

Top module: `stor2ch_regs`

## Requirements
- R1: After reset, every stored field reads 0, each configuration word reads 0x65150000, busRdata is 0, irqOut is 0 and chanReset is 0.
- R2: Read data appears on busRdata at the clock edge that samples busRd, and it holds its value while no read is strobed.
- R3: DMA status byte (channel 0 at 0x02, channel 1 at 0x0A). Bit 0 shows the dmaActive input and is not changed by writes. A write stores data bits 6:5. A 1 written to bit 1 or bit 2 clears that bit. A dmaErrSet pulse sets bit 1 and a dmaIntSet pulse sets bit 2, and a set wins over a clear in the same cycle. All other bits read 0.
- R4: DMA command bytes are at 0x00 and 0x08, and scratch bytes are at 0x01 and 0x09. Writes to 0x10, 0x11, 0x12, 0x18, 0x19 and 0x1A act exactly like writes to the address 0x10 lower. The scratch byte keeps only data bits 5:0.
- R5: A read at 0x10 returns a packed word: channel 0 command in bits 7:0, with bit 4 ORed with channel 0's interrupt flag and bit 6 ORed with channel 1's interrupt flag; bit 14 is channel 1 status bit 2; bits 23:16 are channel 0 status; bits 31:24 are channel 1 status.
- R6: A read at 0x18 returns channel 1's command in bits 7:0 with bit 4 ORed with channel 1's interrupt flag, and channel 1's status in bits 23:16.
- R7: The SATA control field (channel 0 at 0x100, channel 1 at 0x180) stores data bits 11:0. A write with data bit 0 set raises chanReset for that channel for exactly one cycle, starting at the edge after the write.
- R8: The interrupt-enable field (channel 0 at 0x148, channel 1 at 0x1C8) stores data bits 31:16 ANDed with 0x3EED and reads back in bits 31:16.
- R9: A read of the SATA status at 0x104 or 0x184 returns 0x113 when that channel's devPresent bit is high, and 0 otherwise.
- R10: The configuration word (channel 0 at 0xA0, channel 1 at 0xE0) reads 0x6515 in bits 31:16 and the channel's interrupt flag in bit 11. The flag takes the value of devIrq one edge later, and irqOut is the OR of the two flags.
- R11: The task-file window is 0x80–0x87 for channel 0 and 0xC0–0xC7 for channel 1, with tfOfs equal to address bits 2:0. A byte access (size 0) at any offset raises tfReq. A word (size 1) or doubleword (size 2) access raises tfReq only at offset 0. A wide read at another offset returns 0x0000FFFF for size 1 and 0xFFFFFFFF for size 2, and a wide write there raises no request.
- R12: Accesses at 0x04–0x07 (channel 0) and 0x0C–0x0F (channel 1) raise dmaReq for that channel, with dmaOfs equal to address bits 1:0. A read returns that channel's dmaRdata.
- R13: Reads from unmapped offsets return 0, including the alias offsets 0x11, 0x12, 0x19 and 0x1A. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 9 | Byte offset of the access |
| busSize | input | 2 | Access size: 0 byte, 1 word, 2 doubleword |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| dmaActive | input | 2 | Per-channel DMA active flag (status bit 0) |
| dmaErrSet | input | 2 | Per-channel pulse that sets status bit 1 |
| dmaIntSet | input | 2 | Per-channel pulse that sets status bit 2 |
| devPresent | input | 2 | Per-channel device-present flag |
| devIrq | input | 2 | Per-channel device interrupt level |
| tfReq | output | 2 | Per-channel task-file access strobe |
| tfOfs | output | 3 | Task-file register offset |
| tfRdata | input | 64 | Task-file read data, channel 1 in the upper half |
| dmaReq | output | 2 | Per-channel DMA address register access strobe |
| dmaOfs | output | 2 | Byte offset within the DMA address register |
| dmaRdata | input | 64 | DMA address read data, channel 1 in the upper half |
| fwdWe | output | 1 | Forwarded access is a write |
| fwdSize | output | 2 | Forwarded access size |
| fwdWdata | output | 32 | Forwarded write data |
| chanReset | output | 2 | Per-channel one-cycle reset pulse |
| irqOut | output | 1 | Aggregated interrupt |

## Verification
The forwarding strobes tfReq and dmaReq, and their offsets, are combinational, so they are sampled in the same cycle the bus strobe is driven. Read data is due one edge after the read strobe, so each read task drives the strobe at a falling edge and samples busRdata at the next falling edge. Stored fields, the interrupt flags and irqOut change one edge after the write or input change, and the chanReset pulse is checked high one edge after the write and low one edge after that.

// File: rtl/stor2ch_pkg.sv
package stor2ch_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 9;
  localparam int NCH    = 2;
  localparam int SCTL_W = 12;
  localparam int SIEN_W = 16;
  localparam int SCR_W  = 6;
  localparam logic [SIEN_W-1:0] SIEN_MASK = 16'h3EED;
  localparam logic [15:0]       CONF_HI   = 16'h6515;
  localparam logic [DATA_W-1:0] SSTAT_UP  = 32'h113;

  typedef enum logic [3:0] {
    RS_ZERO, RS_CMD, RS_SCR, RS_STAT, RS_PACK0, RS_PACK1, RS_DMAFWD,
    RS_TF, RS_ONES, RS_CONF, RS_SCTL, RS_SSTAT, RS_SIEN
  } rdSel_e;

  typedef struct packed {
    logic [NCH-1:0] cmdWe;
    logic [NCH-1:0] scrWe;
    logic [NCH-1:0] statWe;
    logic [NCH-1:0] sctlWe;
    logic [NCH-1:0] sienWe;
    logic           rdEn;
    rdSel_e         rdSel;
    logic           rdCh;
    logic [1:0]     rdSize;
  } strobe_t;
endpackage

// File: rtl/stor2ch_ctrl.sv
module stor2ch_ctrl
  import stor2ch_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busRd,
  input  logic              busWr,
  output strobe_t           stb,
  output logic [NCH-1:0]    tfReq,
  output logic [NCH-1:0]    dmaReq
);
  logic acc, ch, isAlias;

  always_comb begin
    stb        = '0;
    stb.rdSel  = RS_ZERO;
    stb.rdEn   = busRd;
    stb.rdSize = busSize;
    tfReq      = '0;
    dmaReq     = '0;
    acc        = busRd | busWr;
    ch         = 1'b0;
    isAlias    = 1'b0;
    if (busAddr[ADDR_W-1:5] == '0) begin
      // low DMA block: bit 3 picks the channel, bit 4 the alias
      ch      = busAddr[3];
      isAlias = busAddr[4];
      stb.rdCh = ch;
      case (busAddr[2:0])
        3'd0: begin
          stb.cmdWe[ch] = busWr;
          stb.rdSel = isAlias ? (ch ? RS_PACK1 : RS_PACK0) : RS_CMD;
        end
        3'd1: begin
          stb.scrWe[ch] = busWr;
          if (!isAlias) stb.rdSel = RS_SCR;
        end
        3'd2: begin
          stb.statWe[ch] = busWr;
          if (!isAlias) stb.rdSel = RS_STAT;
        end
        3'd4, 3'd5, 3'd6, 3'd7: begin
          if (!isAlias) begin
            dmaReq[ch] = acc;
            stb.rdSel  = RS_DMAFWD;
          end
        end
        default: ;
      endcase
    end else if (busAddr[ADDR_W-1:ADDR_W-2] == 2'b01) begin
      ch = busAddr[6];
      stb.rdCh = ch;
      if (busAddr[5:3] == 3'd0) begin
        if (busSize == 2'd0 || busAddr[2:0] == 3'd0) begin
          tfReq[ch] = acc;
          stb.rdSel = RS_TF;
        end else begin
          stb.rdSel = RS_ONES;
        end
      end else if (busAddr[5:0] == 6'h20) begin
        stb.rdSel = RS_CONF;
      end
    end else if (busAddr[ADDR_W-1]) begin
      ch = busAddr[7];
      stb.rdCh = ch;
      case (busAddr[6:0])
        7'h00: begin stb.sctlWe[ch] = busWr; stb.rdSel = RS_SCTL; end
        7'h04: stb.rdSel = RS_SSTAT;
        7'h48: begin stb.sienWe[ch] = busWr; stb.rdSel = RS_SIEN; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stor2ch_dp.sv
module stor2ch_dp
  import stor2ch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [NCH-1:0]        dmaActive,
  input  logic [NCH-1:0]        dmaErrSet,
  input  logic [NCH-1:0]        dmaIntSet,
  input  logic [NCH-1:0]        devPresent,
  input  logic [NCH-1:0]        devIrq,
  input  logic [NCH*DATA_W-1:0] tfRdata,
  input  logic [NCH*DATA_W-1:0] dmaRdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic [NCH-1:0]        chanReset,
  output logic                  irqOut
);
  logic [NCH-1:0][7:0]        cmdQ, statQ;
  logic [NCH-1:0][SCR_W-1:0]  scrQ;
  logic [NCH-1:0][SCTL_W-1:0] sctlQ;
  logic [NCH-1:0][SIEN_W-1:0] sienQ;
  logic [NCH-1:0]             irqQ;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [7:0] statNext;
    always_comb begin
      statNext    = statQ[c];
      statNext[0] = dmaActive[c];
      if (stb.statWe[c]) begin
        statNext[6:5] = busWdata[6:5];
        statNext[2:1] = statQ[c][2:1] & ~busWdata[2:1];
      end
      statNext[1] = statNext[1] | dmaErrSet[c];
      statNext[2] = statNext[2] | dmaIntSet[c];
      statNext[7] = 1'b0;
      statNext[4:3] = 2'b00;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdQ[c] <= '0; statQ[c] <= '0; scrQ[c] <= '0;
        sctlQ[c] <= '0; sienQ[c] <= '0; irqQ[c] <= 1'b0;
        chanReset[c] <= 1'b0;
      end else begin
        statQ[c] <= statNext;
        irqQ[c]  <= devIrq[c];
        chanReset[c] <= stb.sctlWe[c] & busWdata[0];
        if (stb.cmdWe[c])  cmdQ[c]  <= busWdata[7:0];
        if (stb.scrWe[c])  scrQ[c]  <= busWdata[SCR_W-1:0];
        if (stb.sctlWe[c]) sctlQ[c] <= busWdata[SCTL_W-1:0];
        if (stb.sienWe[c]) sienQ[c] <= busWdata[DATA_W-1:DATA_W-SIEN_W] & SIEN_MASK;
      end
    end
  end

  logic [DATA_W-1:0] pack0, pack1, rdMux;
  always_comb begin
    pack0        = {statQ[1], statQ[0], 8'h00, cmdQ[0]};
    pack0[4]     = cmdQ[0][4] | irqQ[0];
    pack0[6]     = cmdQ[0][6] | irqQ[1];
    pack0[14]    = statQ[1][2];
    pack1        = {8'h00, statQ[1], 8'h00, cmdQ[1]};
    pack1[4]     = cmdQ[1][4] | irqQ[1];
  end

  always_comb begin
    case (stb.rdSel)
      RS_CMD:    rdMux = {24'h0, cmdQ[stb.rdCh]};
      RS_SCR:    rdMux = {{(DATA_W-SCR_W){1'b0}}, scrQ[stb.rdCh]};
      RS_STAT:   rdMux = {24'h0, statQ[stb.rdCh]};
      RS_PACK0:  rdMux = pack0;
      RS_PACK1:  rdMux = pack1;
      RS_DMAFWD: rdMux = stb.rdCh ? dmaRdata[2*DATA_W-1:DATA_W] : dmaRdata[DATA_W-1:0];
      RS_TF:     rdMux = stb.rdCh ? tfRdata[2*DATA_W-1:DATA_W] : tfRdata[DATA_W-1:0];
      RS_ONES:   rdMux = (stb.rdSize == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
      RS_CONF:   rdMux = {CONF_HI, 4'h0, irqQ[stb.rdCh], 11'h0};
      RS_SCTL:   rdMux = {{(DATA_W-SCTL_W){1'b0}}, sctlQ[stb.rdCh]};
      RS_SSTAT:  rdMux = devPresent[stb.rdCh] ? SSTAT_UP : '0;
      RS_SIEN:   rdMux = {sienQ[stb.rdCh], {(DATA_W-SIEN_W){1'b0}}};
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdMux;
  end

  assign irqOut = |irqQ;
endmodule

// File: rtl/stor2ch_regs.sv
module stor2ch_regs
  import stor2ch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [1:0]            busSize,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NCH-1:0]        dmaActive,
  input  logic [NCH-1:0]        dmaErrSet,
  input  logic [NCH-1:0]        dmaIntSet,
  input  logic [NCH-1:0]        devPresent,
  input  logic [NCH-1:0]        devIrq,
  output logic [NCH-1:0]        tfReq,
  output logic [2:0]            tfOfs,
  input  logic [NCH*DATA_W-1:0] tfRdata,
  output logic [NCH-1:0]        dmaReq,
  output logic [1:0]            dmaOfs,
  input  logic [NCH*DATA_W-1:0] dmaRdata,
  output logic                  fwdWe,
  output logic [1:0]            fwdSize,
  output logic [DATA_W-1:0]     fwdWdata,
  output logic [NCH-1:0]        chanReset,
  output logic                  irqOut
);
  strobe_t stb;

  stor2ch_ctrl u_ctrl (
    .busAddr(busAddr), .busSize(busSize), .busRd(busRd), .busWr(busWr),
    .stb(stb), .tfReq(tfReq), .dmaReq(dmaReq)
  );

  stor2ch_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .dmaActive(dmaActive), .dmaErrSet(dmaErrSet), .dmaIntSet(dmaIntSet),
    .devPresent(devPresent), .devIrq(devIrq), .tfRdata(tfRdata),
    .dmaRdata(dmaRdata), .busRdata(busRdata), .chanReset(chanReset),
    .irqOut(irqOut)
  );

  assign tfOfs    = busAddr[2:0];
  assign dmaOfs   = busAddr[1:0];
  assign fwdWe    = busWr;
  assign fwdSize  = busSize;
  assign fwdWdata = busWdata;
endmodule

// File: rtl/stor2ch_chk.sv
module stor2ch_chk
  import stor2ch_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [1:0]            busSize,
  input logic                  busRd,
  input logic                  busWr,
  input logic [DATA_W-1:0]     busWdata,
  input logic [DATA_W-1:0]     busRdata,
  input logic [NCH-1:0]        devIrq,
  input logic [NCH-1:0]        tfReq,
  input logic [NCH-1:0]        dmaReq,
  input logic [NCH-1:0]        chanReset,
  input logic                  irqOut
);
  AST_IRQ_AGGREGATE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == ($past(devIrq[0]) | $past(devIrq[1]))); // R10

  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 9'h100 && busWdata[0]) |=> chanReset[0]); // R7

  AST_NO_SPURIOUS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr) |=> chanReset == 2'b00); // R7

  AST_FWD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tfReq, dmaReq})); // R11

  AST_WIDE_AT_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (busSize != 2'd0 && tfReq != 2'b00) |-> busAddr[2:0] == 3'd0); // R11

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 9'h030) |=> busRdata == '0); // R13

  AST_SIEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 9'h148) |=> (busRdata & ~32'h3EED_0000) == '0); // R8
endmodule

bind stor2ch_regs stor2ch_chk u_chk (.*);

// File: tb/sim_stor2ch_regs.sv
`timescale 1ns/1ps
module sim_stor2ch_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  dmaActive = '0, dmaErrSet = '0, dmaIntSet = '0;
  logic [1:0]  devPresent = '0, devIrq = '0;
  logic [1:0]  tfReq, dmaReq, chanReset;
  logic [2:0]  tfOfs;
  logic [1:0]  dmaOfs;
  logic        fwdWe, irqOut;
  logic [1:0]  fwdSize;
  logic [31:0] fwdWdata;
  logic [63:0] tfRdata  = {32'hB1B1_0066, 32'hA0A0_0055};
  logic [63:0] dmaRdata = {32'h9ABC_DEF0, 32'h1234_5678};

  int nChecks = 0, nFail = 0;
  logic [1:0] lastTf, lastDma, lastRst;
  logic [2:0] lastTfOfs;
  logic [1:0] lastDmaOfs;
  logic [31:0] rd;

  always #4 clk = ~clk;

  stor2ch_regs u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [8:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    busAddr = a; busSize = sz; busWdata = d; busWr = wr; busRd = ~wr;
    #1;
    lastTf = tfReq; lastDma = dmaReq; lastTfOfs = tfOfs; lastDmaOfs = dmaOfs;
    @(negedge clk);
    r = busRdata; lastRst = chanReset;
    busRd = 1'b0; busWr = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    access(1'b1, a, 2'd2, d, dummy);
  endtask

  task automatic rdChk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] r;
    access(1'b0, a, 2'd2, 32'h0, r);
    check(tag, r, exp);
  endtask

  task automatic tReset();
    check("R1 irqOut", {31'b0, irqOut}, 0);
    check("R1 rdata", busRdata, 0);
    check("R1 chanReset", {30'b0, chanReset}, 0);
    rdChk("R1 cmd0", 9'h000, 0);
    rdChk("R1 stat1", 9'h00A, 0);
    rdChk("R1 sctl1", 9'h180, 0);
    rdChk("R1 sien0", 9'h148, 0);
    rdChk("R1 conf0", 9'h0A0, 32'h6515_0000);
    rdChk("R1 conf1", 9'h0E0, 32'h6515_0000);
  endtask

  task automatic tStatus();
    wr(9'h002, 32'hFF);
    rdChk("R3 rw bits", 9'h002, 32'h60);
    @(negedge clk); dmaIntSet = 2'b01; dmaErrSet = 2'b01;
    @(negedge clk); dmaIntSet = 2'b00; dmaErrSet = 2'b00;
    rdChk("R3 set pulses", 9'h002, 32'h66);
    @(negedge clk); dmaActive = 2'b01;
    rdChk("R3 active bit", 9'h002, 32'h67);
    wr(9'h012, 32'h04);
    rdChk("R3 w1c via alias R4", 9'h002, 32'h03);
    wr(9'h002, 32'h00);
    rdChk("R3 bit0 kept, zero no clear", 9'h002, 32'h03);
    @(negedge clk); dmaIntSet = 2'b01;
    busAddr = 9'h002; busSize = 2'd0; busWdata = 32'h04; busWr = 1'b1;
    @(negedge clk); dmaIntSet = 2'b00; busWr = 1'b0;
    rdChk("R3 set beats clear", 9'h002, 32'h07);
    @(negedge clk); dmaActive = 2'b00;
    wr(9'h002, 32'h66);
    rdChk("R3 clear to 0x60", 9'h002, 32'h60);
  endtask

  task automatic tCmdScratch();
    wr(9'h008, 32'hA5);
    rdChk("R4 cmd1", 9'h008, 32'hA5);
    wr(9'h019, 32'hFF);
    rdChk("R4 scratch1 alias 6-bit", 9'h009, 32'h3F);
    wr(9'h010, 32'h81);
    rdChk("R4 cmd0 alias", 9'h000, 32'h81);
    wr(9'h008, 32'h22);
  endtask

  task automatic tPacked();
    @(negedge clk); dmaIntSet = 2'b10;
    @(negedge clk); dmaIntSet = 2'b00; devIrq = 2'b11;
    @(negedge clk);
    @(negedge clk);
    check("R10 irqOut high", {31'b0, irqOut}, 1);
    rdChk("R5 packed 0x10", 9'h010, 32'h0460_40D1);
    rdChk("R6 packed 0x18", 9'h018, 32'h0004_0032);
    rdChk("R10 conf0 flag", 9'h0A0, 32'h6515_0800);
    @(negedge clk); devIrq = 2'b10;
    @(negedge clk);
    check("R10 irqOut one ch", {31'b0, irqOut}, 1);
    rdChk("R10 conf0 low", 9'h0A0, 32'h6515_0000);
    @(negedge clk); devIrq = 2'b00;
    @(negedge clk);
    check("R10 irqOut low", {31'b0, irqOut}, 0);
  endtask

  task automatic tSctl();
    wr(9'h180, 32'hABCD_1F5E);
    check("R7 no pulse bit0 clear", {30'b0, lastRst}, 0);
    rdChk("R7 sctl1 12 bits", 9'h180, 32'hF5E);
    wr(9'h100, 32'h0000_0301);
    check("R7 pulse high", {30'b0, lastRst}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {30'b0, chanReset}, 0);
    rdChk("R7 sctl0", 9'h100, 32'h301);
  endtask

  task automatic tSien();
    wr(9'h1C8, 32'hFFFF_1234);
    rdChk("R8 sien1", 9'h1C8, 32'h3EED_0000);
    wr(9'h148, 32'h1234_FFFF);
    rdChk("R8 sien0", 9'h148, 32'h1224_0000);
  endtask

  task automatic tSstat();
    @(negedge clk); devPresent = 2'b01;
    rdChk("R9 present", 9'h104, 32'h113);
    rdChk("R9 absent", 9'h184, 32'h0);
  endtask

  task automatic tTaskFile();
    logic [31:0] r;
    access(1'b0, 9'h083, 2'd0, 0, r);
    check("R11 byte req", {30'b0, lastTf}, 1);
    check("R11 byte ofs", {29'b0, lastTfOfs}, 3);
    check("R11 byte data", r, 32'hA0A0_0055);
    access(1'b0, 9'h0C0, 2'd1, 0, r);
    check("R11 word data req", {30'b0, lastTf}, 2);
    check("R11 word data", r, 32'hB1B1_0066);
    access(1'b0, 9'h082, 2'd1, 0, r);
    check("R11 word off-data req", {30'b0, lastTf}, 0);
    check("R11 word ones", r, 32'h0000_FFFF);
    access(1'b0, 9'h0C4, 2'd2, 0, r);
    check("R11 dword ones", r, 32'hFFFF_FFFF);
    access(1'b1, 9'h081, 2'd2, 32'h5555_5555, r);
    check("R11 wide write ignored", {30'b0, lastTf}, 0);
  endtask

  task automatic tDmaFwd();
    logic [31:0] r;
    access(1'b0, 9'h00D, 2'd0, 0, r);
    check("R12 req ch1", {30'b0, lastDma}, 2);
    check("R12 ofs", {30'b0, lastDmaOfs}, 1);
    check("R12 data", r, 32'h9ABC_DEF0);
    access(1'b1, 9'h006, 2'd0, 32'h77, r);
    check("R12 write req ch0", {30'b0, lastDma}, 1);
  endtask

  task automatic tUnmapped();
    wr(9'h030, 32'hFFFF_FFFF);
    rdChk("R13 unmapped", 9'h030, 0);
    rdChk("R13 alias read 0x11", 9'h011, 0);
    rdChk("R13 alias read 0x1A", 9'h01A, 0);
    rdChk("R13 high hole", 9'h1F0, 0);
    wr(9'h1F0, 32'hFFFF_FFFF);
    rdChk("R13 state intact", 9'h008, 32'h22);
    @(negedge clk);
    @(negedge clk);
    check("R2 hold without strobe", busRdata, 32'h22);
  endtask

  initial begin
    #(200000 * 8);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStatus();
    tCmdScratch();
    tPacked();
    tSctl();
    tSien();
    tSstat();
    tTaskFile();
    tDmaFwd();
    tUnmapped();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule